// File: doc/BRIEF.md
# Complex Fixed-Point Multiply-Accumulate Unit

This block multiplies pairs of complex numbers and keeps a running complex sum. Each cycle with a valid input it takes one element from each of two complex sequences, x and y. Each element has a 16-bit real part and a 16-bit imaginary part in signed Q1.15 (bit 15 is the sign, the binary point sits just below it, values span [-1, +1) in steps of 2^-15). The block forms the complex product x·y and adds it into a pair of accumulators, one real and one imaginary.

The accumulators hold four extra integer bits (Q5.15, 20 bits, range [-16, +16)), so partial sums may leave the output range for a while. A clear input starts a new summation. Overflow is reported per lane in two ways. A sticky part latches when a partial sum leaves the extended range and holds until the next clear. A transient part is high only in cycles where the accumulated value fits the extended range but not the Q1.15 output range.

Top module: `cmac_unit`

## Requirements
- R1: The real product term equals floor((x_re·y_re − x_im·y_im) / 2^15). It is computed from the exact double-width sum and then truncated toward minus infinity.
- R2: The imaginary product term equals floor((x_re·y_im + x_im·y_re) / 2^15). It is truncated the same way.
- R3: With in_valid=1 and acc_clear=0, each accumulator adds its product term at the rising edge. The new value appears on the outputs after that edge.
- R4: With acc_clear=1 and in_valid=0, both accumulators become zero and both sticky flags are cleared at the edge.
- R5: With acc_clear=1 and in_valid=1, each accumulator loads its new product term alone and both sticky flags are cleared.
- R6: With in_valid=0 and acc_clear=0, the accumulators and flags keep their values.
- R7: res_re and res_im are the low 16 bits of the respective 20-bit accumulators. These bits are the exact Q1.15 value whenever the accumulator lies in [-1, +1).
- R8: A lane's flag (ovf_re or ovf_im) is high while its accumulator lies outside [-1, +1). The flag falls again once a later product returns the accumulator to that range, provided no sticky overflow occurred.
- R9: When an accumulation leaves [-16, +16), the lane's sticky flag sets and the accumulator keeps the low 20 bits of the sum. The lane flag then stays high until a clear.
- R10: ovf is high exactly when ovf_re or ovf_im is high.
- R11: A synchronous active-high rst zeroes both accumulators and all flags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Current x and y elements are to be used |
| acc_clear | input | 1 | Start a new summation |
| x_re | input | 16 | Real part of x, Q1.15 |
| x_im | input | 16 | Imaginary part of x, Q1.15 |
| y_re | input | 16 | Real part of y, Q1.15 |
| y_im | input | 16 | Imaginary part of y, Q1.15 |
| res_re | output | 16 | Real accumulated result, Q1.15 |
| res_im | output | 16 | Imaginary accumulated result, Q1.15 |
| ovf_re | output | 1 | Real lane overflow (sticky or out of output range) |
| ovf_im | output | 1 | Imaginary lane overflow (sticky or out of output range) |
| ovf | output | 1 | Either lane overflowing |

## Verification
The inputs sampled at a rising edge affect the accumulators, the sticky flags and the out-of-range flags at that same edge. Every result and flag is therefore due one clock after the stimulus, with no further pipeline delay. The bench drives inputs on the falling edge and advances its behavioural model at the rising edge. It compares all five outputs a quarter period after that edge, so each comparison sees exactly the cycle the model predicts. Directed sequences push a sum out of output range and back, drive it past the extended range, and then combine those runs with clears and random traffic.

// File: rtl/cmac_pkg.sv
package cmac_pkg;

    typedef enum logic [1:0] {
        OP_HOLD = 2'd0,
        OP_ACC  = 2'd1,
        OP_LOAD = 2'd2,
        OP_ZERO = 2'd3
    } acc_op_t;

    typedef struct packed {
        logic sticky;
        logic out_range;
    } lane_flags_t;

    function automatic acc_op_t decode_op(input logic valid, input logic clear);
        if (clear)
            return valid ? OP_LOAD : OP_ZERO;
        return valid ? OP_ACC : OP_HOLD;
    endfunction

endpackage

// File: rtl/cmac_prod.sv
module cmac_prod #(
    parameter int DATA_W = 16,
    localparam int FRAC_W = DATA_W - 1,
    localparam int PROD_W = 2 * DATA_W + 1,
    localparam int TERM_W = PROD_W - FRAC_W
) (
    input  logic signed [DATA_W-1:0] x_re,
    input  logic signed [DATA_W-1:0] x_im,
    input  logic signed [DATA_W-1:0] y_re,
    input  logic signed [DATA_W-1:0] y_im,
    output logic signed [TERM_W-1:0] term_re,
    output logic signed [TERM_W-1:0] term_im
);

    logic signed [2*DATA_W-1:0] m_rr, m_ii, m_ri, m_ir;
    logic signed [PROD_W-1:0]   full_re, full_im;

    always_comb begin
        m_rr = x_re * y_re;
        m_ii = x_im * y_im;
        m_ri = x_re * y_im;
        m_ir = x_im * y_re;
        full_re = PROD_W'(m_rr) - PROD_W'(m_ii);
        full_im = PROD_W'(m_ri) + PROD_W'(m_ir);
        // dropping the low fraction bits is a floor division (R1, R2)
        term_re = full_re[PROD_W-1:FRAC_W];
        term_im = full_im[PROD_W-1:FRAC_W];
    end

endmodule

// File: rtl/cmac_lane.sv
module cmac_lane
    import cmac_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int GUARD_W = 4,
    parameter int TERM_W  = DATA_W + 2,
    localparam int FRAC_W = DATA_W - 1,
    localparam int ACC_W  = DATA_W + GUARD_W,
    localparam int SUM_W  = ACC_W + 1
) (
    input  logic                     clk,
    input  logic                     rst,
    input  acc_op_t                  op,
    input  logic signed [TERM_W-1:0] term,
    output logic        [DATA_W-1:0] res,
    output logic                     ovf
);

    logic signed [ACC_W-1:0] acc_q;
    logic signed [SUM_W-1:0] sum;
    logic                    sum_wraps;
    lane_flags_t             flags;
    logic                    sticky_q;
    logic [ACC_W-FRAC_W-1:0] int_bits;

    always_comb begin
        sum       = SUM_W'(acc_q) + SUM_W'(term);
        sum_wraps = sum[SUM_W-1] != sum[SUM_W-2];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            acc_q    <= '0;
            sticky_q <= 1'b0;
        end else begin
            unique case (op)
                OP_ZERO: begin
                    acc_q    <= '0;
                    sticky_q <= 1'b0;
                end
                OP_LOAD: begin
                    acc_q    <= ACC_W'(term);
                    sticky_q <= 1'b0;
                end
                OP_ACC: begin
                    acc_q    <= sum[ACC_W-1:0];
                    sticky_q <= sticky_q | sum_wraps;
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        int_bits        = acc_q[ACC_W-1:FRAC_W];
        flags.sticky    = sticky_q;
        flags.out_range = !((&int_bits) || (~|int_bits));
        res             = acc_q[DATA_W-1:0];
        ovf             = flags.sticky | flags.out_range;
    end

    p_zero_r4: assert property (@(posedge clk) disable iff (rst)
        op == OP_ZERO |=> (acc_q == '0) && !ovf);

    p_load_r5: assert property (@(posedge clk) disable iff (rst)
        op == OP_LOAD |=> (acc_q == ACC_W'($past(term))) && !sticky_q);

    p_hold_r6: assert property (@(posedge clk) disable iff (rst)
        op == OP_HOLD |=> $stable(acc_q) && $stable(sticky_q));

    p_sticky_keep_r9: assert property (@(posedge clk) disable iff (rst)
        (sticky_q && (op == OP_ACC || op == OP_HOLD)) |=> sticky_q && ovf);

endmodule

// File: rtl/cmac_unit.sv
module cmac_unit
    import cmac_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int GUARD_W = 4
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     in_valid,
    input  logic                     acc_clear,
    input  logic signed [DATA_W-1:0] x_re,
    input  logic signed [DATA_W-1:0] x_im,
    input  logic signed [DATA_W-1:0] y_re,
    input  logic signed [DATA_W-1:0] y_im,
    output logic signed [DATA_W-1:0] res_re,
    output logic signed [DATA_W-1:0] res_im,
    output logic                     ovf_re,
    output logic                     ovf_im,
    output logic                     ovf
);

    localparam int TERM_W = DATA_W + 2;
    localparam int LANES  = 2;

    acc_op_t                  op;
    logic signed [TERM_W-1:0] term_re, term_im;
    logic signed [TERM_W-1:0] lane_term [LANES];
    logic        [DATA_W-1:0] lane_res  [LANES];
    logic                     lane_ovf  [LANES];

    assign op = decode_op(in_valid, acc_clear);

    cmac_prod #(.DATA_W(DATA_W)) u_prod (
        .x_re    (x_re),
        .x_im    (x_im),
        .y_re    (y_re),
        .y_im    (y_im),
        .term_re (term_re),
        .term_im (term_im)
    );

    assign lane_term[0] = term_re;
    assign lane_term[1] = term_im;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        cmac_lane #(
            .DATA_W  (DATA_W),
            .GUARD_W (GUARD_W),
            .TERM_W  (TERM_W)
        ) u_lane (
            .clk  (clk),
            .rst  (rst),
            .op   (op),
            .term (lane_term[g]),
            .res  (lane_res[g]),
            .ovf  (lane_ovf[g])
        );
    end

    always_comb begin
        res_re = lane_res[0];
        res_im = lane_res[1];
        ovf_re = lane_ovf[0];
        ovf_im = lane_ovf[1];
        ovf    = lane_ovf[0] | lane_ovf[1];
    end

    p_reset_clear_r11: assert property (@(posedge clk)
        rst |=> (res_re == '0) && (res_im == '0) && !ovf);

endmodule

// File: tb/cmac_unit_test.sv
module cmac_unit_test;

    localparam int CLK_P = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic in_valid = 1'b0;
    logic acc_clear = 1'b0;
    logic signed [15:0] x_re = '0, x_im = '0, y_re = '0, y_im = '0;
    logic signed [15:0] res_re, res_im;
    logic ovf_re, ovf_im, ovf;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 1'b0;

    longint m_acc_re = 0, m_acc_im = 0;
    bit     m_st_re = 1'b0, m_st_im = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    cmac_unit uut (
        .clk(clk), .rst(rst), .in_valid(in_valid), .acc_clear(acc_clear),
        .x_re(x_re), .x_im(x_im), .y_re(y_re), .y_im(y_im),
        .res_re(res_re), .res_im(res_im),
        .ovf_re(ovf_re), .ovf_im(ovf_im), .ovf(ovf)
    );

    function automatic longint wrap(input longint v, input int w);
        longint m = longint'(1) << w;
        longint r = v & (m - 1);
        if (r >= (m >>> 1)) r -= m;
        return r;
    endfunction

    function automatic bit beyond(input longint v);
        return (v < -32768) || (v > 32767);
    endfunction

    task automatic cmp(input string tag, input string what, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all(input string tag);
        bit e_ore = m_st_re | beyond(m_acc_re);
        bit e_oim = m_st_im | beyond(m_acc_im);
        cmp(tag, "res_re", longint'(res_re), wrap(m_acc_re, 16));
        cmp(tag, "res_im", longint'(res_im), wrap(m_acc_im, 16));
        cmp(tag, "ovf_re", longint'(ovf_re), longint'(e_ore));
        cmp(tag, "ovf_im", longint'(ovf_im), longint'(e_oim));
        cmp({tag, "/R10"}, "ovf", longint'(ovf), longint'(e_ore | e_oim));
    endtask

    task automatic step(input string tag, input bit v, input bit c,
                        input logic signed [15:0] a_re, input logic signed [15:0] a_im,
                        input logic signed [15:0] b_re, input logic signed [15:0] b_im);
        longint pr, pi, s;
        @(negedge clk);
        in_valid = v; acc_clear = c;
        x_re = a_re; x_im = a_im; y_re = b_re; y_im = b_im;
        @(posedge clk);
        pr = (longint'(a_re) * longint'(b_re) - longint'(a_im) * longint'(b_im)) >>> 15;
        pi = (longint'(a_re) * longint'(b_im) + longint'(a_im) * longint'(b_re)) >>> 15;
        if (c) begin
            m_acc_re = v ? pr : 0;
            m_acc_im = v ? pi : 0;
            m_st_re = 1'b0; m_st_im = 1'b0;
        end else if (v) begin
            s = m_acc_re + pr;
            if (s < -524288 || s > 524287) m_st_re = 1'b1;
            m_acc_re = wrap(s, 20);
            s = m_acc_im + pi;
            if (s < -524288 || s > 524287) m_st_im = 1'b1;
            m_acc_im = wrap(s, 20);
        end
        #(CLK_P/4);
        check_all(tag);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #(CLK_P/4);
        check_all("R11 reset");

        // load and formula checks
        step("R5 R1 R2 load", 1, 1, 16'sd16384, 16'sd8192, 16'sd16384, -16'sd16384);
        step("R3 R1 R2 acc", 1, 0, -16'sd12345, 16'sd2222, 16'sd3, -16'sd7);
        step("R3 R1 R2 acc neg", 1, 0, -16'sd1, -16'sd1, 16'sd1, 16'sd1);
        step("R6 hold", 0, 0, 16'sd30000, 16'sd30000, 16'sd30000, 16'sd30000);
        step("R6 hold2", 0, 0, -16'sd5, 16'sd9, 16'sd1, 16'sd2);
        step("R4 clear", 0, 1, 16'sd100, 16'sd100, 16'sd100, 16'sd100);

        // transient out-of-range on real lane, then back
        step("R8 R7 load +1", 1, 1, -16'sd32768, 16'sd0, -16'sd32768, 16'sd0);
        step("R8 return", 1, 0, -16'sd32768, 16'sd0, 16'sd16384, 16'sd0);
        step("R7 in range", 1, 0, 16'sd1000, 16'sd2000, 16'sd3000, 16'sd4000);

        // transient on imaginary lane only
        step("R8 R10 im load", 1, 1, -16'sd32768, 16'sd0, 16'sd0, -16'sd32768);
        step("R8 R10 im up", 1, 0, -16'sd32768, 16'sd0, 16'sd0, -16'sd32768);
        step("R8 im back", 1, 0, 16'sd32767, 16'sd0, 16'sd0, -16'sd32768);
        step("R8 im back2", 1, 0, 16'sd32767, 16'sd0, 16'sd0, -16'sd32768);

        // sticky: push the real sum past +16
        step("R4 clear2", 0, 1, 16'sd0, 16'sd0, 16'sd0, 16'sd0);
        for (int i = 0; i < 17; i++)
            step("R9 climb", 1, 0, -16'sd32768, 16'sd0, -16'sd32768, 16'sd0);
        for (int i = 0; i < 20; i++)
            step("R9 stays set", 1, 0, -16'sd32768, 16'sd0, 16'sd32767, 16'sd0);
        step("R9 R6 hold sticky", 0, 0, 16'sd0, 16'sd0, 16'sd0, 16'sd0);
        step("R4 R9 clear sticky", 0, 1, 16'sd0, 16'sd0, 16'sd0, 16'sd0);

        // sticky on imaginary side, downward, then load clears it
        for (int i = 0; i < 18; i++)
            step("R9 im descend", 1, 0, 16'sd32767, 16'sd0, 16'sd0, -16'sd32768);
        step("R5 R9 load clears", 1, 1, 16'sd1, 16'sd2, 16'sd3, 16'sd4);

        // mixed random traffic
        for (int i = 0; i < 600; i++) begin
            logic [31:0] r = $urandom;
            logic [31:0] q = $urandom;
            logic [31:0] u = $urandom;
            step("R1 R2 R3 R8 R9 random", r[0] | r[1], (r[7:2] == 6'd0),
                 q[15:0], q[31:16], u[15:0], u[31:16]);
        end

        // reset mid-sum
        step("R3 pre-reset", 1, 0, -16'sd32768, 16'sd0, -16'sd32768, 16'sd0);
        @(negedge clk);
        rst = 1'b1; in_valid = 1'b0; acc_clear = 1'b0;
        @(posedge clk);
        m_acc_re = 0; m_acc_im = 0; m_st_re = 1'b0; m_st_im = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        #(CLK_P/4);
        check_all("R11 reset again");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule